// File: doc/BRIEF.md
# Host Data Buffer Interface

This block is the slave end of a byte-wide host peripheral port. A host processor talks to it through a chip select, a read strobe, a write strobe, one address line and an 8-bit data bus. A local controller on the other side sees the same exchange through simple one-cycle request pulses. The two directions use separate byte buffers. A host write fills the input buffer, and the local side drains it. The local side fills the output buffer, and a host data read drains it.

An 8-bit status byte reports the buffer flags to both sides. It holds two full flags, a command/data flag set from the address line of the last host write, a local-only flag, and a 4-bit user nibble loaded from the upper half of a local accumulator byte. The host strobes are asynchronous. They pass through a synchroniser, and flags move only after a strobe's rising (trailing) edge has been detected. While the host is reading the status byte, local changes to the status byte are parked. They take effect in the cycle the read's trailing edge is detected.

Top module: `host_data_buffer`

## Requirements
- R1: After synchronous reset, the status byte is 0x00 and both buffers are cleared.
- R2: The status byte bit order is: bits 7:4 user nibble, bit 3 command flag, bit 2 local flag, bit 1 input-full, bit 0 output-full. While chip select and read strobe are both low, `host_dout_en` is 1 and `host_dout` returns the status byte when `host_a0`=1 and the output buffer when `host_a0`=0. Otherwise `host_dout` is 0x00.
- R3: A host write with chip select low loads the input buffer with `host_din`, sets input-full, and copies `host_a0` into the command flag. These take effect on the third rising clock edge after the write strobe rises.
- R4: A local input-buffer read pulse clears input-full on the next clock edge.
- R5: A local output-buffer write pulse loads `loc_obuf_data` and sets output-full on the next clock edge.
- R6: A host read with `host_a0`=0 clears output-full on the third rising clock edge after the read strobe rises.
- R7: A local user-nibble load copies `loc_acc[7:4]` into status bits 7:4 and leaves status bits 3:0 unchanged.
- R8: The local flag changes only on a local flag write; host activity leaves it unchanged.
- R9: While the host reads status (`host_a0`=1) and its synchronised read strobe is low, local status updates are held back. They are applied when the trailing edge is detected. The latest value of each held request wins.
- R10: Strobes with chip select high change neither buffer nor any flag.
- R11: When a set and a clear of the same full flag land on the same edge, the set wins.
- R12: Flags do not change while a host strobe is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_a0 | input | 1 | Host address: 1 selects status/command, 0 selects data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_dout_en | output | 1 | High while the host read cycle is active |
| loc_ibuf_rd | input | 1 | Local read pulse of the input buffer |
| loc_ibuf_data | output | 8 | Input buffer contents |
| loc_obuf_wr | input | 1 | Local write pulse of the output buffer |
| loc_obuf_data | input | 8 | Data for the output buffer |
| loc_f0_wr | input | 1 | Local flag write pulse |
| loc_f0_val | input | 1 | Value for the local flag |
| loc_user_wr | input | 1 | User nibble load pulse |
| loc_acc | input | 8 | Accumulator byte; bits 7:4 feed the user nibble |
| loc_status | output | 8 | Current status byte |

## Verification
On every cycle, the assertions check four things. The user nibble and local flag stay frozen while a status read holds them off. The local flag moves only on local requests. The input-full flag rises only with a detected host write edge. A detected host data read leaves output-full low unless a set lands with it. Some behaviour only the bench scenarios can show: the exact three-edge latency from a strobe's rising edge, the park-and-release of several held requests, set-wins races aligned to the detection cycle, and chip-select gating. The bench shows these against its per-cycle reference model.

// File: rtl/hbb_pkg.sv
// Package: shared types for the host data buffer interface.
// Assumes an 8-bit status byte with the fixed bit order given in the brief.
package hbb_pkg;

    localparam int DATA_W = 8;
    localparam int USER_W = 4;

    typedef struct packed {
        logic [USER_W-1:0] user;
        logic              cmd;
        logic              f0;
        logic              ibf;
        logic              obf;
    } hbb_status_t;

endpackage

// File: rtl/hbb_strobe_sync.sv
// Module: hbb_strobe_sync
// Synchronises one asynchronous active-low host strobe and flags its rising
// (trailing) edge with a single-cycle pulse.
// Assumes STAGES >= 2 and strobe pulses longer than STAGES+1 clock cycles.
module hbb_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active,
    output logic trail
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // First synchroniser flop samples the raw strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= strobe_n;
    end

    // Remaining synchroniser flops.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
        end
    end

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign active = !chain[STAGES-1];
    assign trail  = chain[STAGES-1] & !prev;

    // R12: an edge pulse lasts exactly one cycle.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !trail);

endmodule

// File: rtl/hbb_buffers.sv
// Module: hbb_buffers
// Holds the two data buffers and the host-cycle capture (chip select,
// address and data) taken while a synchronised strobe is low.
// Assumes the host holds cs, a0 and din stable across its strobe.
module hbb_buffers
    import hbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              wr_active,
    input  logic              rd_trail,
    input  logic              wr_trail,
    input  logic              host_cs_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_din,
    input  logic              loc_obuf_wr,
    input  logic [DATA_W-1:0] loc_obuf_data,
    output logic              host_wr_ev,
    output logic              host_rd_ev,
    output logic              wr_a0,
    output logic [DATA_W-1:0] ibuf,
    output logic [DATA_W-1:0] obuf
);

    logic              cap_cs;
    logic              cap_a0;
    logic [DATA_W-1:0] cap_din;

    // Capture the host cycle qualifiers while either strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cs  <= 1'b0;
            cap_a0  <= 1'b0;
            cap_din <= '0;
        end else if (rd_active || wr_active) begin
            cap_cs  <= !host_cs_n;
            cap_a0  <= host_a0;
            cap_din <= host_din;
        end
    end

    assign host_wr_ev = wr_trail & cap_cs;
    assign host_rd_ev = rd_trail & cap_cs & !cap_a0;
    assign wr_a0      = cap_a0;

    // Input buffer: loaded at the end of a selected host write.
    always_ff @(posedge clk) begin
        if (!rst_n)          ibuf <= '0;
        else if (host_wr_ev) ibuf <= cap_din;
    end

    // Output buffer: loaded by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n)           obuf <= '0;
        else if (loc_obuf_wr) obuf <= loc_obuf_data;
    end

    // R3: a host write event leaves the captured byte in the input buffer.
    a_r3_ibuf_load: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_ev |=> ibuf == $past(cap_din));

endmodule

// File: rtl/hbb_status.sv
// Module: hbb_status
// Status byte with host-edge flag updates and a lockout that parks local
// updates while the host reads status, releasing them when the read ends.
// Assumes host events arrive as single-cycle pulses.
module hbb_status
    import hbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              host_wr_ev,
    input  logic              host_wr_a0,
    input  logic              host_rd_ev,
    input  logic              loc_ibf_clr,
    input  logic              loc_obf_set,
    input  logic              loc_f0_wr,
    input  logic              loc_f0_val,
    input  logic              loc_user_wr,
    input  logic [USER_W-1:0] loc_user_val,
    output hbb_status_t       status
);

    logic              pend_ibf_clr;
    logic              pend_obf_set;
    logic              pend_f0_wr;
    logic              pend_f0_val;
    logic              pend_user_wr;
    logic [USER_W-1:0] pend_user_val;
    hbb_status_t       nxt;

    // Next status: released local requests first, then host events; sets win.
    always_comb begin
        nxt = status;
        if (!lock) begin
            if (pend_user_wr) nxt.user = pend_user_val;
            if (loc_user_wr)  nxt.user = loc_user_val;
            if (pend_f0_wr)   nxt.f0   = pend_f0_val;
            if (loc_f0_wr)    nxt.f0   = loc_f0_val;
            if (pend_ibf_clr || loc_ibf_clr) nxt.ibf = 1'b0;
        end
        if (host_wr_ev) begin
            nxt.ibf = 1'b1;
            nxt.cmd = host_wr_a0;
        end
        if (host_rd_ev) nxt.obf = 1'b0;
        if (!lock && (pend_obf_set || loc_obf_set)) nxt.obf = 1'b1;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= nxt;
    end

    // Held local requests: collected under lock, dropped once applied.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock) begin
            pend_ibf_clr  <= 1'b0;
            pend_obf_set  <= 1'b0;
            pend_f0_wr    <= 1'b0;
            pend_f0_val   <= 1'b0;
            pend_user_wr  <= 1'b0;
            pend_user_val <= '0;
        end else begin
            pend_ibf_clr <= pend_ibf_clr | loc_ibf_clr;
            pend_obf_set <= pend_obf_set | loc_obf_set;
            if (loc_f0_wr) begin
                pend_f0_wr  <= 1'b1;
                pend_f0_val <= loc_f0_val;
            end
            if (loc_user_wr) begin
                pend_user_wr  <= 1'b1;
                pend_user_val <= loc_user_val;
            end
        end
    end

    // R9: user nibble and local flag stay frozen under lock.
    a_r9_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable({status.user, status.f0}));

    // R8: the local flag moves only on a local request.
    a_r8_f0_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_f0_wr && !pend_f0_wr) |=> $stable(status.f0));

    // R12: input-full rises only with a host write edge.
    a_r12_ibf_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_ev |=> !$rose(status.ibf));

    // R6: a host data read clears output-full unless a set lands with it.
    a_r6_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_ev && (lock || !(loc_obf_set || pend_obf_set))) |=> !status.obf);

    // R7: an unlocked user load takes effect on the next edge.
    a_r7_user_load: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_user_wr && !lock) |=> status.user == $past(loc_user_val));

endmodule

// File: rtl/host_data_buffer.sv
// Module: host_data_buffer (top)
// Slave side of a byte-wide host port: strobe synchronisers, data buffers
// and the status byte with host-read lockout.
// Assumes host cs/a0/din are stable for the whole strobe and a few cycles
// after it, and that RD and WR are never low together.
module host_data_buffer
    import hbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_dout_en,
    input  logic              loc_ibuf_rd,
    output logic [DATA_W-1:0] loc_ibuf_data,
    input  logic              loc_obuf_wr,
    input  logic [DATA_W-1:0] loc_obuf_data,
    input  logic              loc_f0_wr,
    input  logic              loc_f0_val,
    input  logic              loc_user_wr,
    input  logic [DATA_W-1:0] loc_acc,
    output logic [DATA_W-1:0] loc_status
);

    logic              rd_active, rd_trail;
    logic              wr_active, wr_trail;
    logic              host_wr_ev, host_rd_ev, wr_a0;
    logic              lock;
    logic [DATA_W-1:0] obuf;
    hbb_status_t       status;

    hbb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n),
        .active(rd_active), .trail(rd_trail)
    );

    hbb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n),
        .active(wr_active), .trail(wr_trail)
    );

    hbb_buffers u_bufs (
        .clk(clk), .rst_n(rst_n),
        .rd_active(rd_active), .wr_active(wr_active),
        .rd_trail(rd_trail), .wr_trail(wr_trail),
        .host_cs_n(host_cs_n), .host_a0(host_a0), .host_din(host_din),
        .loc_obuf_wr(loc_obuf_wr), .loc_obuf_data(loc_obuf_data),
        .host_wr_ev(host_wr_ev), .host_rd_ev(host_rd_ev), .wr_a0(wr_a0),
        .ibuf(loc_ibuf_data), .obuf(obuf)
    );

    // Lockout spans a selected status read as seen through the synchroniser.
    assign lock = rd_active & !host_cs_n & host_a0;

    hbb_status u_status (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .host_wr_ev(host_wr_ev), .host_wr_a0(wr_a0), .host_rd_ev(host_rd_ev),
        .loc_ibf_clr(loc_ibuf_rd), .loc_obf_set(loc_obuf_wr),
        .loc_f0_wr(loc_f0_wr), .loc_f0_val(loc_f0_val),
        .loc_user_wr(loc_user_wr), .loc_user_val(loc_acc[DATA_W-1 -: USER_W]),
        .status(status)
    );

    // Host read mux: status or output buffer while the read is active.
    always_comb begin
        host_dout_en = !host_cs_n && !host_rd_n;
        host_dout    = '0;
        if (host_dout_en) host_dout = host_a0 ? status : obuf;
    end

    assign loc_status = status;

endmodule

// File: tb/tb_host_data_buffer.sv
module tb_host_data_buffer;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_dout_en;
    logic       loc_ibuf_rd = 1'b0;
    logic [7:0] loc_ibuf_data;
    logic       loc_obuf_wr = 1'b0;
    logic [7:0] loc_obuf_data = '0;
    logic       loc_f0_wr = 1'b0, loc_f0_val = 1'b0, loc_user_wr = 1'b0;
    logic [7:0] loc_acc = '0;
    logic [7:0] loc_status;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [7:0] mid_stat, mid_dout;

    always #2 clk = ~clk;

    host_data_buffer #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_a0(host_a0), .host_din(host_din),
        .host_dout(host_dout), .host_dout_en(host_dout_en),
        .loc_ibuf_rd(loc_ibuf_rd), .loc_ibuf_data(loc_ibuf_data),
        .loc_obuf_wr(loc_obuf_wr), .loc_obuf_data(loc_obuf_data),
        .loc_f0_wr(loc_f0_wr), .loc_f0_val(loc_f0_val),
        .loc_user_wr(loc_user_wr), .loc_acc(loc_acc),
        .loc_status(loc_status)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       rd_q[$], wr_q[$];
    bit       rd_last, wr_last;
    bit [3:0] m_user;
    bit       m_cmd, m_f0, m_ibf, m_obf;
    bit [7:0] m_ibuf, m_obuf;
    bit       c_cs, c_a0;
    bit [7:0] c_din;
    bit       h_ibf, h_obf, h_f0w, h_f0v, h_uw;
    bit [3:0] h_uv;
    bit       rs, ws, rtr, wtr, lk, wev, rev;

    function automatic bit [7:0] mstat();
        return {m_user, m_cmd, m_f0, m_ibf, m_obf};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_q = {}; wr_q = {};
            for (int i = 0; i < SYNC; i++) begin rd_q.push_back(1'b1); wr_q.push_back(1'b1); end
            rd_last = 1; wr_last = 1;
            {m_user, m_cmd, m_f0, m_ibf, m_obf} = '0;
            m_ibuf = 0; m_obuf = 0; c_cs = 0; c_a0 = 0; c_din = 0;
            {h_ibf, h_obf, h_f0w, h_f0v, h_uw, h_uv} = '0;
        end else begin
            rs  = rd_q[SYNC-1];
            ws  = wr_q[SYNC-1];
            rtr = rs && !rd_last;
            wtr = ws && !wr_last;
            lk  = !rs && !host_cs_n && host_a0;
            wev = wtr && c_cs;
            rev = rtr && c_cs && !c_a0;
            if (!lk) begin
                if (h_uw) m_user = h_uv;
                if (loc_user_wr) m_user = loc_acc[7:4];
                if (h_f0w) m_f0 = h_f0v;
                if (loc_f0_wr) m_f0 = loc_f0_val;
                if (h_ibf || loc_ibuf_rd) m_ibf = 0;
            end
            if (wev) begin m_ibf = 1; m_cmd = c_a0; m_ibuf = c_din; end
            if (rev) m_obf = 0;
            if (!lk && (h_obf || loc_obuf_wr)) m_obf = 1;
            if (loc_obuf_wr) m_obuf = loc_obuf_data;
            if (lk) begin
                h_ibf |= loc_ibuf_rd;
                h_obf |= loc_obuf_wr;
                if (loc_f0_wr)   begin h_f0w = 1; h_f0v = loc_f0_val; end
                if (loc_user_wr) begin h_uw = 1;  h_uv = loc_acc[7:4]; end
            end else begin
                {h_ibf, h_obf, h_f0w, h_f0v, h_uw, h_uv} = '0;
            end
            if (!rs || !ws) begin c_cs = !host_cs_n; c_a0 = host_a0; c_din = host_din; end
            rd_last = rs; wr_last = ws;
            rd_q.push_front(host_rd_n); void'(rd_q.pop_back());
            wr_q.push_front(host_wr_n); void'(wr_q.pop_back());
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 user nibble", loc_status[7:4], m_user);
            chk("R3 command flag", loc_status[3], m_cmd);
            chk("R8 local flag", loc_status[2], m_f0);
            chk("R4 input-full", loc_status[1], m_ibf);
            chk("R5 output-full", loc_status[0], m_obf);
            chk("R3 input buffer", loc_ibuf_data, m_ibuf);
            chk("R2 host_dout", host_dout,
                (!host_cs_n && !host_rd_n) ? (host_a0 ? mstat() : m_obuf) : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse_side(int side, logic [7:0] d);
        case (side)
            1: loc_ibuf_rd = 1;
            2: begin loc_obuf_wr = 1; loc_obuf_data = d; end
            default: ;
        endcase
    endtask

    task automatic host_cycle(bit is_wr, bit sel, bit a0, logic [7:0] d,
                              int side = 0, logic [7:0] sd = 8'h00);
        @(negedge clk);
        host_cs_n = !sel; host_a0 = a0; host_din = d;
        if (is_wr) host_wr_n = 0; else host_rd_n = 0;
        repeat (3) @(negedge clk);
        mid_stat = loc_status; mid_dout = host_dout;
        host_wr_n = 1; host_rd_n = 1;
        repeat (2) @(negedge clk);
        pulse_side(side, sd);
        @(negedge clk);
        loc_ibuf_rd = 0; loc_obuf_wr = 0;
        repeat (3) @(negedge clk);
        host_cs_n = 1;
    endtask

    task automatic loc_pulse(int kind, logic [7:0] d);
        @(negedge clk);
        case (kind)
            1: loc_ibuf_rd = 1;
            2: begin loc_obuf_wr = 1; loc_obuf_data = d; end
            3: begin loc_user_wr = 1; loc_acc = d; end
            4: begin loc_f0_wr = 1; loc_f0_val = d[0]; end
            default: ;
        endcase
        @(negedge clk);
        loc_ibuf_rd = 0; loc_obuf_wr = 0; loc_user_wr = 0; loc_f0_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", loc_status, 8'h00);
        chk("R1 reset ibuf", loc_ibuf_data, 8'h00);

        host_cycle(1, 1, 0, 8'hA5);
        chk("R12 no change while strobe low", mid_stat, 8'h00);
        chk("R3 data write status", loc_status, 8'h02);
        chk("R3 data write byte", loc_ibuf_data, 8'hA5);
        loc_pulse(1, 0);
        chk("R4 local read clears", loc_status, 8'h00);

        host_cycle(1, 1, 1, 8'h3C);
        chk("R3 command write status", loc_status, 8'h0A);
        loc_pulse(1, 0);
        chk("R4 local read clears", loc_status, 8'h08);

        loc_pulse(2, 8'h5A);
        chk("R5 output write", loc_status, 8'h09);
        host_cycle(0, 1, 0, 8'h00);
        chk("R2 data read returns buffer", mid_dout, 8'h5A);
        chk("R6 data read clears output-full", loc_status, 8'h08);

        loc_pulse(3, 8'hB7);
        chk("R7 user load keeps low nibble", loc_status, 8'hB8);
        loc_pulse(4, 8'h01);
        chk("R8 local flag set", loc_status, 8'hBC);
        host_cycle(1, 1, 0, 8'h11);
        chk("R8 local flag kept by host write", loc_status, 8'hB6);
        loc_pulse(1, 0);

        // R9 lockout during a host status read
        @(negedge clk);
        host_cs_n = 0; host_a0 = 1; host_rd_n = 0;
        repeat (3) @(negedge clk);
        chk("R2 status read returns status", host_dout, 8'hB4);
        loc_pulse(3, 8'h40);
        loc_pulse(4, 8'h00);
        loc_pulse(2, 8'h77);
        loc_pulse(3, 8'h90);
        loc_pulse(3, 8'h40);
        @(negedge clk);
        chk("R9 status held under lock", loc_status, 8'hB4);
        host_rd_n = 1;
        repeat (3) @(negedge clk);
        chk("R9 held updates applied", loc_status, 8'h41);
        host_cs_n = 1;

        host_cycle(1, 0, 1, 8'hEE);
        chk("R10 deselected write ignored", loc_status, 8'h41);
        chk("R10 deselected write keeps buffer", loc_ibuf_data, 8'h11);
        host_cycle(0, 0, 0, 8'h00);
        chk("R10 deselected read ignored", loc_status, 8'h41);

        host_cycle(1, 1, 0, 8'h22);
        host_cycle(1, 1, 0, 8'h33, 1);
        chk("R11 host set beats local clear", loc_status, 8'h43);
        host_cycle(0, 1, 0, 8'h00, 2, 8'h99);
        chk("R11 local set beats host clear", loc_status, 8'h43);
        host_cycle(0, 1, 0, 8'h00);
        chk("R2 read returns newest byte", mid_dout, 8'h99);
        chk("R6 second read clears", loc_status, 8'h42);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule